// File: doc/BRIEF.md
# Lockable Peripheral Control Register

This block is a single 8-bit control register on a simple memory-mapped bus. It fans out decoded control lines to nearby clock, watchdog, serial and pad logic. One bit acts as a one-way unlock. Software can set it but never clear it. Only the hard reset or the soft reset returns it to 0. While this unlock bit is 0, the three protected fields (wait clock stop, watchdog clock source and signal output stop) ignore writes.

The two low bits choose which pin carries the transmit clock:

| Bits 1:0 | Mode | Pin used |
|---|---|---|
| 00 | Single-clock | Main clock pin |
| 01 | Plural-clock | Main clock pin |
| 10 | Plural-clock | First auxiliary pin |
| 11 | Plural-clock | Second auxiliary pin |

The two top bits turn on pad pull-ups. These two bits are write-only, and their readback value is not defined. Software must write the whole byte each time. A single-bit set or clear done as a read-modify-write would copy the undefined top bits back into the register.

The unlock test uses the value the unlock bit held before the write. A write that sets the unlock bit therefore cannot also load the protected bits in the same cycle.

Top module: `xfn_cfg_reg`

## Requirements
- R1: After the hard reset, all eight stored bits are 0. Every flag output is low, `pluralClkMode` is 0, and `clkPinSel` is 3'b001.
- R2: Bit 5 (`expEnable`) becomes 1 when a write with bit 5 set is accepted. A later write with bit 5 at 0 leaves it at 1.
- R3: When bit 5 was 0 before a write, bits 4:2 keep their value. This also holds when the same write sets bit 5.
- R4: When bit 5 was already 1, an accepted write loads bits 4:2 from the write data.
- R5: Bits 1:0 select the clock pin through the one-hot `clkPinSel`, where bit 0 is the main pin, bit 1 is auxiliary pin 0 and bit 2 is auxiliary pin 1. Value 00 gives 3'b001 with `pluralClkMode`=0. Value 01 gives 3'b001, value 10 gives 3'b010 and value 11 gives 3'b100, each with `pluralClkMode`=1.
- R6: Bit 2 drives `waitClkStop` and bit 4 drives `sigOutStop`. Bit 3 drives both `wdtSrcPeriph` and `wdtDivStop`.
- R7: Bit 6 drives `pullGrpEn` and bit 7 drives `pullPinEn`. Readback bits 7:6 are unspecified.
- R8: A write is accepted only when `busWrEn`, `busByteEn` are high and `busAddr` equals `REG_ADDR`. Any other write leaves every output unchanged.
- R9: When `busAddr` equals `REG_ADDR`, `busRdData[5:0]` shows stored bits 5:0. At any other address, `busRdData` is 0.
- R10: `softRst` clears all eight bits, including bit 5, on the next clock edge. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous active-high soft reset |
| busAddr | input | ADDR_W | Bus address |
| busWrEn | input | 1 | Write strobe |
| busByteEn | input | 1 | Byte enable for the register byte |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| clkPinSel | output | 3 | One-hot transmit clock pin select |
| pluralClkMode | output | 1 | Plural-clock mode active |
| waitClkStop | output | 1 | Stop internal clocks in wait |
| wdtSrcPeriph | output | 1 | Watchdog clocked from peripheral divider |
| wdtDivStop | output | 1 | Stop the dedicated watchdog divider |
| sigOutStop | output | 1 | Signal output stop |
| pullGrpEn | output | 1 | Pull-up enable, four-pin group |
| pullPinEn | output | 1 | Pull-up enable, single pin |
| expEnable | output | 1 | Sticky unlock bit |

## Verification
The bench builds the block with `ADDR_W`=4 and `REG_ADDR`=4'h9. The narrow address keeps the address space small, so writes to a neighbouring address (4'h8) give a cheap test of address rejection. The default byte-wide address behaves the same way. Every readback check masks bits 7:6, and the pull-up fields are checked only through their output pins.

// File: rtl/xfn_cfg_pkg.sv
package xfn_cfg_pkg;
  localparam int REG_W     = 8;
  localparam int PIN_CNT   = 3;
  localparam int SEL_LO    = 0;
  localparam int SEL_HI    = 1;
  localparam int GATED_LO  = 2;
  localparam int GATED_HI  = 4;
  localparam int STICKY_B  = 5;
  localparam int PULLG_B   = 6;
  localparam int PULLP_B   = 7;

  typedef struct packed {
    logic loadOpen;   // bits 1:0 and 7:6
    logic loadGated;  // bits 4:2
    logic setSticky;  // bit 5 may go to 1
    logic clearAll;   // soft reset
  } regStrobe_t;
endpackage

// File: rtl/xfn_cfg_ctrl.sv
module xfn_cfg_ctrl
  import xfn_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busByteEn,
  input  logic              softRst,
  input  logic              unlocked,
  output regStrobe_t        strobe,
  output logic              addrHit
);
  logic wrAccept;

  always_comb begin
    addrHit  = (busAddr == REG_ADDR);
    wrAccept = busWrEn && busByteEn && addrHit && !softRst;
    strobe.clearAll  = softRst;
    strobe.loadOpen  = wrAccept;
    strobe.setSticky = wrAccept;
    // unlock decision uses the stored bit, i.e. the value before this write
    strobe.loadGated = wrAccept && unlocked;
  end
endmodule

// File: rtl/xfn_cfg_dpath.sv
module xfn_cfg_dpath
  import xfn_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             hardRstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] cfgQ,
  output logic [PIN_CNT-1:0] clkPinSel,
  output logic             pluralClkMode
);
  logic [REG_W-1:0] cfgNext;
  logic [1:0]       pinCode;

  always_comb begin
    cfgNext = cfgQ;
    if (strobe.clearAll) begin
      cfgNext = '0;
    end else begin
      if (strobe.loadOpen) begin
        cfgNext[SEL_HI:SEL_LO] = wrData[SEL_HI:SEL_LO];
        cfgNext[PULLG_B]       = wrData[PULLG_B];
        cfgNext[PULLP_B]       = wrData[PULLP_B];
      end
      if (strobe.loadGated)
        cfgNext[GATED_HI:GATED_LO] = wrData[GATED_HI:GATED_LO];
      if (strobe.setSticky)
        cfgNext[STICKY_B] = cfgQ[STICKY_B] | wrData[STICKY_B];
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) cfgQ <= '0;
    else           cfgQ <= cfgNext;
  end

  assign pinCode       = cfgQ[SEL_HI:SEL_LO];
  assign pluralClkMode = (pinCode != 2'b00);

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    if (p == 0) begin : g_main
      assign clkPinSel[p] = (pinCode == 2'b00) || (pinCode == 2'b01);
    end else begin : g_aux
      assign clkPinSel[p] = (pinCode == 2'(p + 1));
    end
  end
endmodule

// File: rtl/xfn_cfg_reg.sv
module xfn_cfg_reg
  import xfn_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busByteEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [2:0]        clkPinSel,
  output logic              pluralClkMode,
  output logic              waitClkStop,
  output logic              wdtSrcPeriph,
  output logic              wdtDivStop,
  output logic              sigOutStop,
  output logic              pullGrpEn,
  output logic              pullPinEn,
  output logic              expEnable
);
  regStrobe_t       strobe;
  logic             addrHit;
  logic [REG_W-1:0] cfgQ;

  xfn_cfg_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busByteEn(busByteEn),
    .softRst  (softRst),
    .unlocked (cfgQ[STICKY_B]),
    .strobe   (strobe),
    .addrHit  (addrHit)
  );

  xfn_cfg_dpath u_dpath (
    .clk          (clk),
    .hardRstN     (hardRstN),
    .strobe       (strobe),
    .wrData       (busWrData),
    .cfgQ         (cfgQ),
    .clkPinSel    (clkPinSel),
    .pluralClkMode(pluralClkMode)
  );

  assign waitClkStop  = cfgQ[2];
  assign wdtSrcPeriph = cfgQ[3];
  assign wdtDivStop   = cfgQ[3];
  assign sigOutStop   = cfgQ[4];
  assign expEnable    = cfgQ[STICKY_B];
  assign pullGrpEn    = cfgQ[PULLG_B];
  assign pullPinEn    = cfgQ[PULLP_B];
  // write-only bits 7:6 return 0 here
  assign busRdData    = addrHit ? {2'b00, cfgQ[5:0]} : 8'h00;
endmodule

// File: rtl/xfn_cfg_chk.sv
module xfn_cfg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h2C
) (
  input logic              clk,
  input logic              hardRstN,
  input logic              softRst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busByteEn,
  input logic [2:0]        clkPinSel,
  input logic              pluralClkMode,
  input logic              waitClkStop,
  input logic              wdtSrcPeriph,
  input logic              sigOutStop,
  input logic              pullGrpEn,
  input logic              pullPinEn,
  input logic              expEnable
);
  logic noWrite;
  assign noWrite = !busWrEn || !busByteEn || (busAddr != REG_ADDR);

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (expEnable && !softRst) |=> expEnable);

  // R3
  locked_gate_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (!expEnable && !softRst) |=> $stable({waitClkStop, wdtSrcPeriph, sigOutStop}));

  // R5
  pin_onehot_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    $countones(clkPinSel) == 1);

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    (noWrite && !softRst) |=> $stable({clkPinSel, pluralClkMode, waitClkStop,
      wdtSrcPeriph, sigOutStop, pullGrpEn, pullPinEn, expEnable}));

  // R10
  soft_clear_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    softRst |=> (!expEnable && !pullGrpEn && !pullPinEn && !waitClkStop &&
      clkPinSel == 3'b001 && !pluralClkMode));
endmodule

bind xfn_cfg_reg xfn_cfg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .busAddr(busAddr),
  .busWrEn(busWrEn), .busByteEn(busByteEn), .clkPinSel(clkPinSel),
  .pluralClkMode(pluralClkMode), .waitClkStop(waitClkStop),
  .wdtSrcPeriph(wdtSrcPeriph), .sigOutStop(sigOutStop),
  .pullGrpEn(pullGrpEn), .pullPinEn(pullPinEn), .expEnable(expEnable)
);

// File: tb/xfn_cfg_reg_tb.sv
`timescale 1ns/1ps
module xfn_cfg_reg_tb;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] REG_ADDR = 4'h9;
  localparam int NVEC = 6;
  // {write data, expected readback[5:0], expected clkPinSel}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h1C, 6'h00, 3'b001},  // R3 locked: bits 4:2 dropped
    {8'h3D, 6'h21, 3'b001},  // R3 bit5 set same write, gated bits dropped
    {8'h1E, 6'h3E, 3'b010},  // R2 bit5 held, R4 gated load
    {8'h07, 6'h27, 3'b100},  // R4 gated reload, R5 aux1
    {8'hC8, 6'h28, 3'b001},  // R4, R5 code 00
    {8'h30, 6'h30, 3'b001}   // R4, R5
  };

  logic clk = 0, hardRstN = 0, softRst = 0;
  logic [ADDR_W-1:0] busAddr = REG_ADDR;
  logic busWrEn = 0, busByteEn = 0;
  logic [7:0] busWrData = 0, busRdData;
  logic [2:0] clkPinSel;
  logic pluralClkMode, waitClkStop, wdtSrcPeriph, wdtDivStop, sigOutStop;
  logic pullGrpEn, pullPinEn, expEnable;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xfn_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic be, logic [7:0] d);
    busAddr = a; busByteEn = be; busWrEn = 1; busWrData = d;
    @(negedge clk);
    busWrEn = 0; busByteEn = 0; busAddr = REG_ADDR;
    #1;
  endtask

  function automatic logic [7:0] flags();
    return {1'b0, pluralClkMode, pullPinEn, pullGrpEn, sigOutStop,
            wdtDivStop, wdtSrcPeriph, waitClkStop};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R1 reset readback", busRdData & 8'h3F, 8'h00);
    check("R1 reset flags", flags(), 8'h00);
    check("R1 reset pin", {5'b0, clkPinSel}, 8'h01);
    hardRstN = 1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      wr(REG_ADDR, 1'b1, VEC[i][16:9]);
      check($sformatf("R2/R3/R4 vec%0d readback", i), busRdData & 8'h3F, {2'b0, VEC[i][8:3]});
      check($sformatf("R5 vec%0d pin", i), {5'b0, clkPinSel}, {5'b0, VEC[i][2:0]});
    end
    // state: 0x30. R6 flags
    wr(REG_ADDR, 1'b1, 8'h1D);
    check("R6 flags bits2-4 set code01", flags(), 8'h4F);
    check("R5 plural with main pin", {5'b0, clkPinSel}, 8'h01);
    // R7 pull-ups
    wr(REG_ADDR, 1'b1, 8'h40);
    check("R7 group pull", {6'b0, pullPinEn, pullGrpEn}, 8'h01);
    wr(REG_ADDR, 1'b1, 8'h80);
    check("R7 pin pull", {6'b0, pullPinEn, pullGrpEn}, 8'h02);
    // R8 rejected writes; state 0x20 with bit7
    wr(4'h8, 1'b1, 8'h1F);
    check("R8 wrong address", flags(), 8'h20);
    wr(REG_ADDR, 1'b0, 8'h1F);
    check("R8 no byte enable", flags(), 8'h20);
    // R9 read at other address
    busAddr = 4'h8; #1;
    check("R9 other address reads 0", busRdData, 8'h00);
    busAddr = REG_ADDR; #1;
    check("R9 register readback", busRdData & 8'h3F, 8'h20);
    // R10 soft reset beats simultaneous write
    softRst = 1;
    wr(REG_ADDR, 1'b1, 8'hFF);
    softRst = 0;
    check("R10 soft reset readback", busRdData & 8'h3F, 8'h00);
    check("R10 soft reset pulls", {6'b0, pullPinEn, pullGrpEn}, 8'h00);
    // R3 after soft reset locked again
    wr(REG_ADDR, 1'b1, 8'h1C);
    check("R3 relocked after soft reset", busRdData & 8'h3F, 8'h00);
    // R1 hard reset clears sticky bit
    wr(REG_ADDR, 1'b1, 8'h20);
    check("R2 set again", {7'b0, expEnable}, 8'h01);
    hardRstN = 0; #2;
    check("R1 hard reset clears sticky", {7'b0, expEnable}, 8'h00);
    hardRstN = 1;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule